// File: doc/BRIEF.md
# Keyboard-Controller Output Port and Reset Pulse Control

This block keeps the 8-bit output port of a PC-style keyboard controller. It accepts command bytes from the controller's command decoder and direct port-write bytes. From these it drives the A20 gate line and raises a system reset request. The two commands that control A20 change only bit 1 of the port. Every command in the 0xF0..0xFF group is a request to pulse port bits low. Of those bits, only bit 0, which is wired to the processor reset, has any effect. A direct port write that clears bit 0 also requests a reset.

The reset request is one clock wide. A second output stretches it to a nominal width of about 6 us. That width is derived from the clock frequency and the pulse duration parameters. Port bits 4 and 5 carry no stored state. They show the keyboard and auxiliary buffer-full flags that the output-buffer arbiter supplies.

Top module: `outport_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the stored port value is 0xCF. With both buffer-full flags low, `port_value` reads 0xCF. `a20_gate` is 1, and `rst_req` and `rst_stretched` are 0.
- R2: Command 0xDF sets port bit 1 and drives `a20_gate` high from the clock edge that samples it. All other stored bits are unchanged.
- R3: Command 0xDD clears port bit 1 and drives `a20_gate` low from the clock edge that samples it. All other stored bits are unchanged.
- R4: A command whose upper nibble is 0xF and whose bit 0 is 0 (for example 0xFE or 0xF0) makes `rst_req` high for exactly the one cycle after the edge that samples it. The stored port value is left unchanged.
- R5: A command whose upper nibble is 0xF and whose bit 0 is 1 (for example 0xFF) changes neither the port nor `a20_gate`, and raises no reset request.
- R6: A direct port write stores the whole byte. `a20_gate` then follows bit 1 of the written byte.
- R7: A direct port write whose bit 0 is 0 makes `rst_req` high for one cycle after the edge that samples it.
- R8: `port_value` bit 4 always equals `obf_kbd` and bit 5 always equals `obf_aux`, whatever was written.
- R9: `rst_stretched` goes high one cycle after `rst_req` and stays high for exactly PULSE_CYCLES = CLK_KHZ*PULSE_NS/1e6 cycles (1500 with the defaults). A new request during the pulse restarts the full count.
- R10: Any other command byte has no effect on the port, on `a20_gate` or on the reset outputs.
- R11: When a direct port write and an A20 command arrive in the same cycle, the written byte wins. A reset is requested if either input asks for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte from the command decoder |
| port_wr | input | 1 | Direct output-port write strobe |
| port_wdata | input | 8 | Byte for the direct output-port write |
| obf_kbd | input | 1 | Keyboard buffer-full flag, shown on port bit 4 |
| obf_aux | input | 1 | Auxiliary buffer-full flag, shown on port bit 5 |
| port_value | output | 8 | Current output-port value |
| a20_gate | output | 1 | A20 gate line (port bit 1) |
| rst_req | output | 1 | Single-cycle system reset request |
| rst_stretched | output | 1 | Reset request stretched to the nominal pulse width |

## Verification
The hardest state to reach from the ports is a reset request that arrives while an earlier stretched pulse is still running. In that state the restart of the count competes with its natural end. The random stimulus sends a reset-causing command or write often enough that such requests land at many different points of a running pulse. A directed case also fires a second request partway through a pulse. A third directed case lets one pulse run undisturbed and counts its full length. A further directed case drives a port write and an A20 command in the same cycle.

// File: rtl/outport_pkg.sv
// Shared constants and types for the output-port controller.
// Assumes command bytes and port bytes are 8 bits wide.
package outport_pkg;
    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_GATE_ON  = 8'hDF;
    localparam logic [BYTE_W-1:0] OP_GATE_OFF = 8'hDD;
    localparam logic [3:0]        OP_PULSE_HI = 4'hF;

    localparam logic [BYTE_W-1:0] PORT_INIT   = 8'hCF;

    localparam int unsigned BIT_RESET = 0;
    localparam int unsigned BIT_GATE  = 1;
    localparam int unsigned BIT_FLAGK = 4;
    localparam int unsigned BIT_FLAGA = 5;

    typedef struct packed {
        logic gate_on;
        logic gate_off;
        logic pulse_rst;
    } cmd_act_t;
endpackage

// File: rtl/outport_cmd_decode.sv
// Combinational command classifier.
// Turns a valid command byte into at most one action: raise A20, lower A20,
// or pulse the reset bit. Pulse-group commands with bit 0 set, and all
// unlisted bytes, give no action.
module outport_cmd_decode
    import outport_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_act_t          act
);
    logic in_pulse_group;

    // Classify the pulse group by its upper nibble.
    always_comb begin
        in_pulse_group = (cmd_byte[BYTE_W-1:4] == OP_PULSE_HI);
    end

    // Produce the action flags for a valid command.
    always_comb begin
        act           = '0;
        act.gate_on   = cmd_valid && (cmd_byte == OP_GATE_ON);
        act.gate_off  = cmd_valid && (cmd_byte == OP_GATE_OFF);
        act.pulse_rst = cmd_valid && in_pulse_group && !cmd_byte[BIT_RESET];
    end
endmodule

// File: rtl/outport_port_reg.sv
// Output-port storage, A20 gate and single-cycle reset request.
// A direct write takes precedence over A20 commands in the same cycle.
// Bits 4 and 5 of the visible value come from the arbiter flags.
// Assumes act holds at most one action (see the decoder).
module outport_port_reg
    import outport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_act_t          act,
    input  logic              port_wr,
    input  logic [BYTE_W-1:0] port_wdata,
    input  logic              obf_kbd,
    input  logic              obf_aux,
    output logic [BYTE_W-1:0] port_value,
    output logic              a20_gate,
    output logic              rst_req
);
    logic [BYTE_W-1:0] port_q;
    logic              wr_rst;

    // A written byte with a low reset bit asks for a reset.
    always_comb begin
        wr_rst = port_wr && !port_wdata[BIT_RESET];
    end

    // Update the stored port: write first, then A20 commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= PORT_INIT;
        end else if (port_wr) begin
            port_q <= port_wdata;
        end else if (act.gate_on) begin
            port_q[BIT_GATE] <= 1'b1;
        end else if (act.gate_off) begin
            port_q[BIT_GATE] <= 1'b0;
        end
    end

    // Register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= act.pulse_rst || wr_rst;
        end
    end

    // Merge the live buffer-full flags into the visible port value.
    always_comb begin
        port_value            = port_q;
        port_value[BIT_FLAGK] = obf_kbd;
        port_value[BIT_FLAGA] = obf_aux;
        a20_gate              = port_q[BIT_GATE];
    end

    assert_one_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

    assert_gate_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act.gate_on && !port_wr) |=> a20_gate);

    assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act.gate_off && !port_wr) |=> !a20_gate);

    assert_write_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> (a20_gate == $past(port_wdata[BIT_GATE])));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !act.pulse_rst && !wr_rst) |=> !rst_req);
endmodule

// File: rtl/outport_rst_stretch.sv
// Stretches the one-cycle reset request to PULSE_CYCLES cycles.
// A new request reloads the full count, even during a running pulse.
// Assumes PULSE_CYCLES >= 1.
module outport_rst_stretch #(
    parameter int unsigned PULSE_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic stretched
);
    localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trigger) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The pulse lasts while the count is nonzero.
    always_comb begin
        stretched = (cnt_q != '0);
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

    assert_follows_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> stretched);

    assert_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretched) |-> $past(trigger));
endmodule

// File: rtl/outport_ctrl.sv
// Top level of the keyboard-controller output-port block.
// Decodes commands, keeps the port register, drives A20 and produces
// both a one-cycle and a stretched reset request. The stretched width is
// CLK_KHZ * PULSE_NS / 1e6 cycles, and never less than one cycle.
module outport_ctrl
    import outport_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 250000,
    parameter int unsigned PULSE_NS = 6000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       port_wr,
    input  logic [7:0] port_wdata,
    input  logic       obf_kbd,
    input  logic       obf_aux,
    output logic [7:0] port_value,
    output logic       a20_gate,
    output logic       rst_req,
    output logic       rst_stretched
);
    localparam longint unsigned PULSE_RAW =
        (longint'(CLK_KHZ) * longint'(PULSE_NS)) / 64'd1000000;
    localparam int unsigned PULSE_CYCLES =
        (PULSE_RAW == 0) ? 1 : int'(PULSE_RAW);

    cmd_act_t act;

    outport_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .act       (act)
    );

    outport_port_reg u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .port_wr    (port_wr),
        .port_wdata (port_wdata),
        .obf_kbd    (obf_kbd),
        .obf_aux    (obf_aux),
        .port_value (port_value),
        .a20_gate   (a20_gate),
        .rst_req    (rst_req)
    );

    outport_rst_stretch #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger   (rst_req),
        .stretched (rst_stretched)
    );

    // R4, R7: every reset request has a cause at the ports one cycle earlier.
    assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past((cmd_valid && cmd_byte[7:4] == 4'hF && !cmd_byte[0])
                          || (port_wr && !port_wdata[0])));

    // R5, R10: without a write or an A20 command the stored bits hold.
    assert_port_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(port_wr) && !($past(cmd_valid) &&
          ($past(cmd_byte) == 8'hDF || $past(cmd_byte) == 8'hDD)))
        |-> ((port_value & 8'hCF) == ($past(port_value) & 8'hCF)));
endmodule

// File: tb/outport_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: random commands and writes from a fixed seed, mixed
// with directed corner cases. A cycle-level reference model kept in the
// bench supplies the expected values.
module outport_ctrl_tb;
    localparam int unsigned PULSE = (250000 * 6000) / 1000000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       port_wr = 1'b0;
    logic [7:0] port_wdata = 8'h00;
    logic       obf_kbd = 1'b0;
    logic       obf_aux = 1'b0;
    logic [7:0] port_value;
    logic       a20_gate;
    logic       rst_req;
    logic       rst_stretched;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] m_port = 8'hCF;
    logic       m_req = 1'b0;
    int         m_cnt = 0;

    always #2 clk = ~clk;

    outport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .port_wr(port_wr), .port_wdata(port_wdata), .obf_kbd(obf_kbd),
        .obf_aux(obf_aux), .port_value(port_value), .a20_gate(a20_gate),
        .rst_req(rst_req), .rst_stretched(rst_stretched)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_req(input logic cv, input logic [7:0] cb,
                                     input logic pw, input logic [7:0] pd);
        return (cv && cb[7:4] == 4'hF && !cb[0]) || (pw && !pd[0]);
    endfunction

    function automatic logic [7:0] exp_port(input logic [7:0] old, input logic cv,
                                            input logic [7:0] cb, input logic pw,
                                            input logic [7:0] pd);
        logic [7:0] n = old;
        if (pw) n = pd;
        else if (cv && cb == 8'hDF) n[1] = 1'b1;
        else if (cv && cb == 8'hDD) n[1] = 1'b0;
        return n;
    endfunction

    // One clock: drive at a falling edge, update the model at the rising edge,
    // check at the next falling edge and return the inputs to idle.
    task automatic step(input logic cv, input logic [7:0] cb, input logic pw,
                        input logic [7:0] pd, input logic fk, input logic fa);
        string tp, tr;
        cmd_valid = cv; cmd_byte = cb; port_wr = pw; port_wdata = pd;
        obf_kbd = fk; obf_aux = fa;
        @(posedge clk);
        if (m_req) m_cnt = PULSE;
        else if (m_cnt != 0) m_cnt--;
        m_req  = exp_req(cv, cb, pw, pd);
        m_port = exp_port(m_port, cv, cb, pw, pd);
        @(negedge clk);
        if (pw && cv && (cb == 8'hDF || cb == 8'hDD)) tp = "R11";
        else if (pw) tp = "R6";
        else if (cv && cb == 8'hDF) tp = "R2";
        else if (cv && cb == 8'hDD) tp = "R3";
        else if (cv && cb[7:4] == 4'hF) tp = cb[0] ? "R5" : "R4";
        else tp = "R10";
        if (pw && !pd[0]) tr = "R7";
        else if (cv && cb[7:4] == 4'hF) tr = cb[0] ? "R5" : "R4";
        else tr = "R10";
        chk(tp, int'(port_value & 8'hCF), int'(m_port & 8'hCF));
        chk(tp, int'(a20_gate), int'(m_port[1]));
        chk("R8", int'(port_value[5:4]), int'({fa, fk}));
        chk(tr, int'(rst_req), int'(m_req));
        chk("R9", int'(rst_stretched), int'(m_cnt != 0));
        cmd_valid = 1'b0; port_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 8'h00, obf_kbd, obf_aux);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int len;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", int'(port_value), 8'hCF);
        chk("R1", int'(a20_gate), 1);
        chk("R1", int'(rst_req), 0);
        chk("R1", int'(rst_stretched), 0);

        // Directed corners
        step(1'b1, 8'hDD, 1'b0, 8'h00, 1'b0, 1'b0);   // R3
        step(1'b1, 8'hDF, 1'b0, 8'h00, 1'b1, 1'b0);   // R2
        step(1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b1);   // R5
        step(1'b1, 8'hA7, 1'b0, 8'h00, 1'b1, 1'b1);   // R10
        step(1'b0, 8'h00, 1'b1, 8'h3D, 1'b0, 1'b0);   // R6, R8: bits 4/5 not stored visibly
        step(1'b1, 8'hDF, 1'b1, 8'h01, 1'b0, 1'b0);   // R11: write wins
        step(1'b1, 8'hF0, 1'b1, 8'hFF, 1'b0, 1'b0);   // R11: reset from command
        idle(2);
        // R9: full stretched length, undisturbed
        idle(PULSE + 2);
        step(1'b1, 8'hFE, 1'b0, 8'h00, 1'b0, 1'b0);
        len = 0;
        idle(1);
        while (rst_stretched && len < PULSE + 10) begin
            len++;
            idle(1);
        end
        chk("R9", len, PULSE);
        // R9: retrigger midway through a pulse
        step(1'b0, 8'h00, 1'b1, 8'hCE, 1'b0, 1'b0);   // R7
        idle(PULSE / 2);
        step(1'b1, 8'hF2, 1'b0, 8'h00, 1'b0, 1'b0);   // R4
        idle(PULSE + 3);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic cv, pw, fk, fa;
            logic [7:0] cb, pd;
            r  = $urandom % 100;
            cv = 1'b0; pw = 1'b0; cb = 8'h00; pd = 8'h00;
            fk = 1'($urandom); fa = 1'($urandom);
            if (r < 20) begin cv = 1'b1; cb = ($urandom % 2) ? 8'hDF : 8'hDD; end
            else if (r < 30) begin cv = 1'b1; cb = {4'hF, 4'($urandom)}; end
            else if (r < 45) begin cv = 1'b1; cb = 8'($urandom); end
            else if (r < 65) begin pw = 1'b1; pd = 8'($urandom) | 8'h01; end
            else if (r < 68) begin pw = 1'b1; pd = 8'($urandom); end
            else if (r < 72) begin
                cv = 1'b1; cb = 8'($urandom); pw = 1'b1; pd = 8'($urandom) | 8'h01;
            end
            step(cv, cb, pw, pd, fk, fa);
        end
        idle(PULSE + 2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule